// File: doc/BRIEF.md
# Tear-Free Frame Buffer Flip Controller

This block sits between a renderer and a scan-out engine that share two frame buffers in memory. From a single pixel clock it runs a horizontal and a vertical scan counter against timing values loaded at run time (active span, front porch, sync width and back porch on each axis). From those counters it produces the two sync outputs, each with its own selectable polarity, the current pixel coordinates and a flag that marks the visible area.

One buffer is the front buffer, which the display reads. The other is the back buffer, which the renderer writes. The block outputs the base address of each buffer and the index of the front one. When the renderer pulses `frame_done`, the roles of the two buffers are exchanged. With `lock_en` high, the exchange is held until the scan reaches vertical sync, so that a frame is never shown half old and half new. While the exchange is pending, `back_ready` is low, and the renderer must wait for it before it starts the next frame. With `lock_en` low, the exchange takes effect on the next clock edge wherever the scan is. The lines still to be shown in that frame then come from the new buffer.

The flip logic is a two-state machine:
- **ST_DRAW**: the renderer may write. `back_ready` is 1.
- **ST_HOLD**: a finished frame waits for vertical sync. `back_ready` is 0.

Transitions:
- **DRAW→DRAW with flip**: `frame_done` arrives while unlocked, or arrives in the last cycle before vertical sync.
- **DRAW→HOLD**: `frame_done` arrives while locked, at any other cycle.
- **HOLD→DRAW with flip**: the last cycle before vertical sync is reached, or `lock_en` has been dropped.
- **HOLD→HOLD**: all other cycles. A `frame_done` in this state is ignored.

Top module: `frame_flip_ctrl`

## Requirements
- R1: `pix_x` counts 0 to Htot-1, where Htot = h_act+h_fp+h_sw+h_bp, and then wraps to 0. `pix_y` advances by one when `pix_x` wraps, and it wraps to 0 after line Vtot-1, where Vtot is the sum of the four vertical values. All timing values must be at least 1.
- R2: the horizontal sync is logically asserted while h_act+h_fp ≤ `pix_x` < h_act+h_fp+h_sw. `hsync_o` equals that level when `hs_pol`=1 and its inverse when `hs_pol`=0.
- R3: the vertical sync is logically asserted on whole lines with v_act+v_fp ≤ `pix_y` < v_act+v_fp+v_sw. `vsync_o` follows `vs_pol` in the same way as `hsync_o` follows `hs_pol`.
- R4: `disp_active` is 1 exactly when `pix_x` < h_act and `pix_y` < v_act.
- R5: reset gives `pix_x`=0, `pix_y`=0, `front_idx`=0 and `back_ready`=1 (state ST_DRAW).
- R6: `rd_base` is BASE0 when `front_idx`=0 and BASE1 when `front_idx`=1. `wr_base` is always the other base.
- R7: with `lock_en`=1, a `frame_done` while `back_ready`=1 drops `back_ready` from the next cycle. `front_idx` then stays put until the edge at which the scan enters the first vertical sync line (`pix_x`=0, `pix_y`=v_act+v_fp). At that edge `front_idx` toggles and `back_ready` returns to 1, so locked flips are always a whole number of frames apart.
- R8: with `lock_en`=1, a `frame_done` in the last cycle before vertical sync (`pix_x`=Htot-1, `pix_y`=v_act+v_fp-1) toggles `front_idx` at that same edge, and `back_ready` stays 1.
- R9: with `lock_en`=0, a `frame_done` toggles `front_idx` at the next edge regardless of the scan position, and `back_ready` stays 1.
- R10: a `frame_done` while `back_ready`=0 has no effect. Only one toggle follows the pending request.
- R11: if `lock_en` goes low while a flip is pending, the flip happens at the next edge and `back_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_act | input | H_W | Visible pixels per line |
| h_fp | input | H_W | Horizontal front porch, in pixels |
| h_sw | input | H_W | Horizontal sync width, in pixels |
| h_bp | input | H_W | Horizontal back porch, in pixels |
| v_act | input | V_W | Visible lines per frame |
| v_fp | input | V_W | Vertical front porch, in lines |
| v_sw | input | V_W | Vertical sync width, in lines |
| v_bp | input | V_W | Vertical back porch, in lines |
| hs_pol | input | 1 | 1: `hsync_o` is active high. 0: active low |
| vs_pol | input | 1 | 1: `vsync_o` is active high. 0: active low |
| lock_en | input | 1 | 1: hold flips until vertical sync |
| frame_done | input | 1 | One-cycle pulse from the renderer marking a finished back buffer |
| hsync_o | output | 1 | Horizontal sync pin level |
| vsync_o | output | 1 | Vertical sync pin level |
| pix_x | output | H_W+2 | Current pixel column |
| pix_y | output | V_W+2 | Current line |
| disp_active | output | 1 | Visible area flag |
| front_idx | output | 1 | Index of the buffer being displayed |
| back_ready | output | 1 | Renderer may write the back buffer |
| rd_base | output | A_W | Base address for display reads |
| wr_base | output | A_W | Base address for renderer writes |

## Verification
The flip logic is driven with `frame_done` pulses at several scan positions:
- **Mid-frame pulses while locked**: show whether a flip is deferred to vertical sync or leaks into the visible scan.
- **A pulse in the exact cycle before sync**: separates same-edge acceptance from a one-frame delay.
- **A repeated pulse while held**: exposes a double toggle.
- **A pulse in the middle of the visible area while unlocked**: confirms the immediate, tearing flip.
- **Dropping `lock_en` during a hold**: checks that a pending flip is released.

Two timing sets with opposite sync polarities separate region-boundary and polarity errors. A behavioural model compares every output each cycle, and the bench also counts the lines between locked flips to show that each gap is a whole number of frames.

// File: rtl/frame_flip_pkg.sv
package frame_flip_pkg;
    typedef enum logic [0:0] {
        ST_DRAW = 1'b0,
        ST_HOLD = 1'b1
    } flip_state_e;
endpackage

// File: rtl/scan_axis.sv
// One scan axis: a counter over active + front porch + sync + back porch,
// with region flags. The counter advances only when step is high.
module scan_axis #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] act,
    input  logic [W-1:0] fp,
    input  logic [W-1:0] sw,
    input  logic [W-1:0] bp,
    output logic [W+1:0] cnt,
    output logic         wrap,
    output logic         in_act,
    output logic         in_sync,
    output logic         pre_sync
);
    localparam int CW = W + 2;

    logic [CW-1:0] sync_lo;
    logic [CW-1:0] sync_hi;
    logic [CW-1:0] total;

    always_comb begin
        sync_lo  = CW'(act) + CW'(fp);
        sync_hi  = sync_lo + CW'(sw);
        total    = sync_hi + CW'(bp);
        wrap     = step && (cnt >= total - CW'(1));
        in_act   = cnt < CW'(act);
        in_sync  = (cnt >= sync_lo) && (cnt < sync_hi);
        pre_sync = (cnt == sync_lo - CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else if (step)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/flip_fsm.sv
// Buffer role exchange: immediate when unlocked, held until the vertical
// sync edge when locked.
module flip_fsm
    import frame_flip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_en,
    input  logic frame_done,
    input  logic vs_edge,
    output logic front_idx,
    output logic back_ready
);
    flip_state_e state;
    flip_state_e state_nx;
    logic        flip;

    always_comb begin
        state_nx = state;
        flip     = 1'b0;
        unique case (state)
            ST_DRAW: begin
                if (frame_done) begin
                    if (!lock_en || vs_edge)
                        flip = 1'b1;
                    else
                        state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (vs_edge || !lock_en) begin
                    flip     = 1'b1;
                    state_nx = ST_DRAW;
                end
            end
            default: state_nx = ST_DRAW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_DRAW;
            front_idx <= 1'b0;
        end else begin
            state     <= state_nx;
            front_idx <= front_idx ^ flip;
        end
    end

    always_comb begin
        back_ready = (state == ST_DRAW);
    end
endmodule

// File: rtl/frame_flip_ctrl.sv
module frame_flip_ctrl #(
    parameter int              H_W   = 12,
    parameter int              V_W   = 12,
    parameter int              A_W   = 32,
    parameter logic [A_W-1:0]  BASE0 = 32'h0000_0000,
    parameter logic [A_W-1:0]  BASE1 = 32'h0080_0000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [H_W-1:0] h_act,
    input  logic [H_W-1:0] h_fp,
    input  logic [H_W-1:0] h_sw,
    input  logic [H_W-1:0] h_bp,
    input  logic [V_W-1:0] v_act,
    input  logic [V_W-1:0] v_fp,
    input  logic [V_W-1:0] v_sw,
    input  logic [V_W-1:0] v_bp,
    input  logic           hs_pol,
    input  logic           vs_pol,
    input  logic           lock_en,
    input  logic           frame_done,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic [H_W+1:0] pix_x,
    output logic [V_W+1:0] pix_y,
    output logic           disp_active,
    output logic           front_idx,
    output logic           back_ready,
    output logic [A_W-1:0] rd_base,
    output logic [A_W-1:0] wr_base
);
    logic h_wrap, h_act_f, h_sync_f, h_pre;
    logic v_wrap, v_act_f, v_sync_f, v_pre;
    logic vs_edge;

    scan_axis #(.W(H_W)) u_h (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .act(h_act), .fp(h_fp), .sw(h_sw), .bp(h_bp),
        .cnt(pix_x), .wrap(h_wrap), .in_act(h_act_f),
        .in_sync(h_sync_f), .pre_sync(h_pre)
    );

    scan_axis #(.W(V_W)) u_v (
        .clk(clk), .rst_n(rst_n), .step(h_wrap),
        .act(v_act), .fp(v_fp), .sw(v_sw), .bp(v_bp),
        .cnt(pix_y), .wrap(v_wrap), .in_act(v_act_f),
        .in_sync(v_sync_f), .pre_sync(v_pre)
    );

    // Last cycle before the first vertical sync line begins.
    assign vs_edge = h_wrap && v_pre;

    flip_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .lock_en(lock_en),
        .frame_done(frame_done), .vs_edge(vs_edge),
        .front_idx(front_idx), .back_ready(back_ready)
    );

    always_comb begin
        hsync_o     = ~(h_sync_f ^ hs_pol);
        vsync_o     = ~(v_sync_f ^ vs_pol);
        disp_active = h_act_f && v_act_f;
        rd_base     = front_idx ? BASE1 : BASE0;
        wr_base     = front_idx ? BASE0 : BASE1;
    end
endmodule

// File: rtl/frame_flip_chk.sv
module frame_flip_chk #(
    parameter int H_W = 12,
    parameter int V_W = 12,
    parameter int A_W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [H_W-1:0] h_act,
    input logic [H_W-1:0] h_fp,
    input logic [H_W-1:0] h_sw,
    input logic [H_W-1:0] h_bp,
    input logic [V_W-1:0] v_act,
    input logic [V_W-1:0] v_fp,
    input logic           lock_en,
    input logic           frame_done,
    input logic [H_W+1:0] pix_x,
    input logic [V_W+1:0] pix_y,
    input logic           front_idx,
    input logic           back_ready,
    input logic [A_W-1:0] rd_base,
    input logic [A_W-1:0] wr_base
);
    logic [H_W+1:0] htot;
    logic [V_W+1:0] vs_line;
    logic           pre;

    always_comb begin
        htot    = (H_W+2)'(h_act) + (H_W+2)'(h_fp) + (H_W+2)'(h_sw) + (H_W+2)'(h_bp);
        vs_line = (V_W+2)'(v_act) + (V_W+2)'(v_fp);
        pre     = (pix_x == htot - (H_W+2)'(1)) && (pix_y == vs_line - (V_W+2)'(1));
    end

    p_x_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_x < htot);

    p_bases_differ_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_base != wr_base);

    p_lock_flip_at_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((front_idx != $past(front_idx)) && $past(lock_en)) |->
            (pix_x == '0 && pix_y == vs_line));

    p_hold_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_en && frame_done && back_ready && !pre) |=> !back_ready);

    p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_en && frame_done && back_ready && pre) |=>
            (back_ready && front_idx != $past(front_idx)));

    p_unlocked_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_en && frame_done && back_ready) |=>
            (back_ready && front_idx != $past(front_idx)));

    p_hold_keeps_front_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!back_ready && lock_en && !pre) |=> $stable(front_idx));
endmodule

bind frame_flip_ctrl frame_flip_chk #(.H_W(H_W), .V_W(V_W), .A_W(A_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .h_act(h_act), .h_fp(h_fp), .h_sw(h_sw),
    .h_bp(h_bp), .v_act(v_act), .v_fp(v_fp), .lock_en(lock_en),
    .frame_done(frame_done), .pix_x(pix_x), .pix_y(pix_y),
    .front_idx(front_idx), .back_ready(back_ready),
    .rd_base(rd_base), .wr_base(wr_base)
);

// File: tb/sim_frame_flip_ctrl.sv
`timescale 1ns/1ps
module sim_frame_flip_ctrl;
    localparam logic [31:0] B0 = 32'h0000_0000;
    localparam logic [31:0] B1 = 32'h0080_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] h_act, h_fp, h_sw, h_bp, v_act, v_fp, v_sw, v_bp;
    logic hs_pol, vs_pol, lock_en, frame_done;
    logic hsync_o, vsync_o, disp_active, front_idx, back_ready;
    logic [13:0] pix_x, pix_y;
    logic [31:0] rd_base, wr_base;

    int HA, HF, HS, HB, VA, VF, VS, VB;
    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    // reference model state
    int  mx, my, mf;
    bit  mhold, lock_s;
    int  prev_front, line_cnt;
    bit  have_prev;

    always #2.5 clk = ~clk;

    frame_flip_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .h_act(h_act), .h_fp(h_fp), .h_sw(h_sw),
        .h_bp(h_bp), .v_act(v_act), .v_fp(v_fp), .v_sw(v_sw), .v_bp(v_bp),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .lock_en(lock_en),
        .frame_done(frame_done), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .pix_x(pix_x), .pix_y(pix_y), .disp_active(disp_active),
        .front_idx(front_idx), .back_ready(back_ready),
        .rd_base(rd_base), .wr_base(wr_base)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int htot(); return HA + HF + HS + HB; endfunction
    function automatic int vtot(); return VA + VF + VS + VB; endfunction

    task automatic set_timing(input int a, input int b, input int c, input int d,
                              input int e, input int f, input int g, input int h);
        HA = a; HF = b; HS = c; HB = d; VA = e; VF = f; VS = g; VB = h;
        h_act = 12'(a); h_fp = 12'(b); h_sw = 12'(c); h_bp = 12'(d);
        v_act = 12'(e); v_fp = 12'(f); v_sw = 12'(g); v_bp = 12'(h);
    endtask

    // Per-cycle reference model and full comparison
    always @(posedge clk) begin
        bit pre, flip;
        lock_s = lock_en;
        if (!rst_n) begin
            mx = 0; my = 0; mf = 0; mhold = 0;
            prev_front = 0; line_cnt = 0; have_prev = 0;
        end else begin
            pre  = (mx == htot() - 1) && (my == VA + VF - 1);
            flip = 0;
            if (!mhold) begin
                if (frame_done) begin
                    if (!lock_en || pre) flip = 1;
                    else mhold = 1;
                end
            end else if (pre || !lock_en) begin
                flip = 1; mhold = 0;
            end
            if (flip) mf = 1 - mf;
            if (mx == htot() - 1) begin
                mx = 0;
                my = (my == vtot() - 1) ? 0 : my + 1;
            end else mx = mx + 1;
        end
        #1;
        if (rst_n) begin
            bit hs_l, vs_l;
            hs_l = (mx >= HA + HF) && (mx < HA + HF + HS);
            vs_l = (my >= VA + VF) && (my < VA + VF + VS);
            chk(int'(pix_x) == mx, "R1 pix_x", pix_x, mx);
            chk(int'(pix_y) == my, "R1 pix_y", pix_y, my);
            chk(hsync_o == (hs_pol ? hs_l : !hs_l), "R2 hsync", hsync_o, hs_pol ? hs_l : !hs_l);
            chk(vsync_o == (vs_pol ? vs_l : !vs_l), "R3 vsync", vsync_o, vs_pol ? vs_l : !vs_l);
            chk(disp_active == ((mx < HA) && (my < VA)), "R4 active", disp_active, (mx < HA) && (my < VA));
            chk(int'(front_idx) == mf, "R7 front", front_idx, mf);
            chk(back_ready == !mhold, "R7 ready", back_ready, !mhold);
            chk(rd_base == (mf ? B1 : B0) && wr_base == (mf ? B0 : B1), "R6 bases", rd_base, mf ? B1 : B0);
            // line counting between locked flips (R7)
            if (int'(front_idx) != prev_front) begin
                if (lock_s) begin
                    chk(pix_x == 0 && int'(pix_y) == VA + VF, "R7 flip position", pix_y, VA + VF);
                    if (have_prev)
                        chk(line_cnt % vtot() == 0, "R7 lines between flips", line_cnt, vtot());
                    have_prev = 1;
                end else have_prev = 0;
                line_cnt   = 1;
                prev_front = front_idx;
            end else if (pix_x == 0) line_cnt++;
        end
    end

    task automatic wait_xy(input int x, input int y);
        forever begin
            @(negedge clk);
            if (int'(pix_x) == x && int'(pix_y) == y) break;
        end
    endtask

    task automatic pulse_done();
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done_run) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        frame_done = 0; lock_en = 1; hs_pol = 1; vs_pol = 1;
        set_timing(8, 2, 3, 3, 6, 2, 2, 2);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R5: reset state, sampled before the first active edge
        chk(pix_x == 0 && pix_y == 0, "R5 counters", {pix_y, pix_x}, 0);
        chk(front_idx == 0, "R5 front", front_idx, 0);
        chk(back_ready == 1, "R5 ready", back_ready, 1);
        chk(rd_base == B0, "R5 R6 rd_base", rd_base, B0);
        repeat (htot() * vtot()) @(negedge clk);

        // R4 boundaries
        wait_xy(HA - 1, VA - 1);
        chk(disp_active == 1, "R4 last visible", disp_active, 1);
        wait_xy(HA, 0);
        chk(disp_active == 0, "R4 first blank", disp_active, 0);

        // R7 held flip and R10 ignored repeat
        wait_xy(3, 1);
        pulse_done();
        chk(back_ready == 0, "R7 ready drops", back_ready, 0);
        chk(front_idx == 0, "R7 no early flip", front_idx, 0);
        wait_xy(5, 2);
        pulse_done();
        wait_xy(0, VA + VF);
        chk(front_idx == 1, "R7 R10 single flip at sync", front_idx, 1);
        chk(back_ready == 1, "R7 ready back", back_ready, 1);

        // R8 request in the last cycle before sync
        wait_xy(htot() - 1, VA + VF - 1);
        pulse_done();
        chk(front_idx == 0, "R8 same-edge flip", front_idx, 0);
        chk(back_ready == 1, "R8 ready stays", back_ready, 1);
        chk(int'(pix_y) == VA + VF, "R8 line", pix_y, VA + VF);

        wait_xy(2, 3);
        pulse_done();
        repeat (2 * htot() * vtot()) @(negedge clk);

        // R9 unlocked flip mid-scan
        lock_en = 1'b0;
        wait_xy(4, 2);
        pulse_done();
        chk(front_idx == 0, "R9 immediate flip", front_idx, 0);
        chk(int'(pix_y) == 2, "R9 mid-frame", pix_y, 2);
        chk(back_ready == 1, "R9 ready", back_ready, 1);

        // R11 lock dropped during hold
        lock_en = 1'b1;
        wait_xy(1, 1);
        pulse_done();
        chk(back_ready == 0, "R11 held", back_ready, 0);
        lock_en = 1'b0;
        @(negedge clk);
        chk(front_idx == 1, "R11 released flip", front_idx, 1);
        chk(back_ready == 1, "R11 ready", back_ready, 1);
        lock_en = 1'b1;
        repeat (htot() * vtot()) @(negedge clk);

        // Second timing set, active-low syncs
        rst_n = 1'b0;
        hs_pol = 0; vs_pol = 0;
        set_timing(5, 1, 2, 2, 4, 1, 1, 2);
        @(negedge clk);
        chk(hsync_o == 1 && vsync_o == 1, "R2 R3 idle high", {hsync_o, vsync_o}, 2'b11);
        rst_n = 1'b1;
        wait_xy(HA + HF, 0);
        chk(hsync_o == 0, "R2 low-active sync", hsync_o, 0);
        chk(disp_active == 0, "R4 porch", disp_active, 0);
        wait_xy(0, VA + VF);
        chk(vsync_o == 0, "R3 low-active sync", vsync_o, 0);
        for (int i = 0; i < 4; i++) begin
            wait_xy(i + 1, i % VA);
            pulse_done();
            repeat (htot() * vtot()) @(negedge clk);
        end
        done_run = 1'b1;
        finish_run();
    end
endmodule